// File: doc/BRIEF.md
# Chained Serial DAC Load Controller

This block sits on the host side of a group of 16-bit serial-input digital-to-analog converters. It turns an array of codes and a start pulse into the waveforms those converters expect. The outputs are a slow data clock, serial data, input-register enables, a load (update) enable and a clear pulse. All of them come from a faster system clock, using cycle counts derived from nanosecond minimums.

Two wirings are supported. With cascaded wiring, every converter's serial output feeds the next one's input. The controller streams 16 bits per device in one unbroken frame and then strobes the shared load enable once. With parallel wiring, all converters share clock and data but each has its own input enable. The controller writes the devices one at a time and then either updates the outputs after each write or updates all of them together at the end. The wiring and update choice are static inputs, captured at start. A separate clear request drives a clear pulse of guaranteed minimum width.

Top module: `sdac_chain_ctrl`

## Requirements
- R1: Cascaded mode (mode_par=0): the code vector is sent as one frame of NDEV*WORD_W bits, most significant bit first. Bits [NDEV*WORD_W-1 -: WORD_W] go out first, so after the transaction the device at chain position d (0 nearest the controller) holds codes[d*WORD_W +: WORD_W].
- R2: Cascaded mode strobes load_n low exactly once, after the last data bit, for one dclk rising edge. A transaction therefore has NDEV*WORD_W+1 dclk rising edges.
- R3: Parallel mode (mode_par=1): devices are written one at a time, highest index first. At most one bit of shift_n is low at any time, and bit d is low only while device d's WORD_W bits are clocked. Device d ends up holding codes[d*WORD_W +: WORD_W].
- R4: In parallel mode with upd_each=1, load_n is strobed after every device write, giving NDEV load strobes and NDEV*(WORD_W+1) dclk rises. With upd_each=0 there is a single load strobe at the end, giving NDEV*WORD_W+1 rises.
- R5: dclk stays high for at least ceil(T_HI_NS/CLK_NS) system cycles and low for at least ceil(max(T_LO_NS,T_SU_NS)/CLK_NS). One high phase plus one low phase covers at least T_PER_NS.
- R6: sdata, shift_n and load_n are unchanged for at least the low-phase count of cycles before each dclk rise. sdata changes only at dclk falls, which gives hold time.
- R7: clr_go while idle drives clr_n low for at least ceil(T_CLR_NS/CLK_NS) cycles, and the transaction completes with done. When clr_go and start arrive together, clr_go wins and no data is clocked.
- R8: load_n and any bit of shift_n are never low in the same cycle.
- R9: busy is high from the cycle after an accepted start (or clear) until the cycle after done. done is a one-cycle pulse. A start while busy is ignored.
- R10: After reset: busy=0, done=0, dclk=0, sdata=0, shift_n all ones, load_n=1, clr_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_par | input | 1 | 0 = cascaded wiring, 1 = parallel wiring (captured at start) |
| upd_each | input | 1 | Parallel mode: 1 = update after each device, 0 = update all at end |
| start | input | 1 | Start a write transaction (ignored while busy) |
| clr_go | input | 1 | Issue a clear pulse (ignored while busy, wins over start) |
| codes | input | NDEV*WORD_W | Codes; device d uses bits [d*WORD_W +: WORD_W] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| dclk | output | 1 | Serial data clock to the converters |
| sdata | output | 1 | Serial data, MSB first |
| shift_n | output | NDEV | Active-low input-register enables (all low together in cascaded mode) |
| load_n | output | 1 | Active-low shared load (update) enable |
| clr_n | output | 1 | Active-low clear pulse |

## Verification
The bench builds the block with NDEV=3, WORD_W=16 and CLK_NS=4. That gives 13-cycle high and low phases and a 50-cycle clear. A three-deep chain is the smallest one in which a middle device both receives and forwards a word, so ordering errors show up at a device that is neither first nor last. With these values every transaction is short enough to run all three wiring and update combinations with random codes. Directed runs cover the extreme two's-complement codes, clear priority and a start arriving mid-frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLO,
    ST_BHI,
    ST_GAP,
    ST_LLO,
    ST_LHI,
    ST_CLR,
    ST_FIN
  } sdac_st_e;

  // Smallest cycle count whose duration covers ns
  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !ld) |=> zero);

endmodule

// File: rtl/sdac_word_shifter.sv
module sdac_word_shifter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (ld)     sr <= ld_val;
    else if (shift)  sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

  // R1
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (msb == $past(ld_val[W-1])));

endmodule

// File: rtl/sdac_chain_ctrl.sv
module sdac_chain_ctrl
  import sdac_pkg::*;
#(
  parameter int NDEV     = 3,
  parameter int WORD_W   = 16,
  parameter int CLK_NS   = 4,
  parameter int T_HI_NS  = 50,
  parameter int T_LO_NS  = 50,
  parameter int T_PER_NS = 100,
  parameter int T_SU_NS  = 50,
  parameter int T_CLR_NS = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_par,
  input  logic                   upd_each,
  input  logic                   start,
  input  logic                   clr_go,
  input  logic [NDEV*WORD_W-1:0] codes,
  output logic                   busy,
  output logic                   done,
  output logic                   dclk,
  output logic                   sdata,
  output logic [NDEV-1:0]        shift_n,
  output logic                   load_n,
  output logic                   clr_n
);

  localparam int TOT     = NDEV * WORD_W;
  localparam int LO_CNT  = imax(1, cyc_ceil(imax(T_LO_NS, T_SU_NS), CLK_NS));
  localparam int HI_BASE = imax(1, cyc_ceil(T_HI_NS, CLK_NS));
  localparam int PER_CNT = cyc_ceil(T_PER_NS, CLK_NS);
  localparam int HI_CNT  = imax(HI_BASE, PER_CNT - LO_CNT);
  localparam int CLR_CNT = imax(1, cyc_ceil(T_CLR_NS, CLK_NS));
  localparam int CMAX    = imax(imax(LO_CNT, HI_CNT), CLR_CNT);
  localparam int TW      = $clog2(CMAX + 1);
  localparam int BW      = (TOT > 1) ? $clog2(TOT) : 1;
  localparam int DW      = (NDEV > 1) ? $clog2(NDEV) : 1;

  localparam logic [TW-1:0] LO_M1  = TW'(LO_CNT - 1);
  localparam logic [TW-1:0] HI_M1  = TW'(HI_CNT - 1);
  localparam logic [TW-1:0] CLR_M1 = TW'(CLR_CNT - 1);

  sdac_st_e        st, st_d;
  logic            par_q, each_q;
  logic [BW-1:0]   bit_cnt;
  logic [DW-1:0]   dev;
  logic            tmr_ld, tmr_zero;
  logic [TW-1:0]   tmr_val;
  logic            sh_ld, sh_go, sh_msb;
  logic            bit_clr, bit_inc, dev_dec, dev_set;
  logic            bit_last, load_here, in_bits;

  sdac_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
  );

  sdac_word_shifter #(.W(TOT)) u_sh (
    .clk(clk), .rst_n(rst_n), .ld(sh_ld), .ld_val(codes), .shift(sh_go), .msb(sh_msb)
  );

  // Frame end: one word per device in parallel, whole chain in cascade
  assign bit_last  = par_q ? (bit_cnt == BW'(WORD_W - 1)) : (bit_cnt == BW'(TOT - 1));
  assign load_here = !par_q || each_q || (dev == '0);

  always_comb begin
    st_d    = st;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    sh_ld   = 1'b0;
    sh_go   = 1'b0;
    bit_clr = 1'b0;
    bit_inc = 1'b0;
    dev_dec = 1'b0;
    dev_set = 1'b0;
    case (st)
      ST_IDLE: begin
        if (clr_go) begin
          st_d = ST_CLR; tmr_ld = 1'b1; tmr_val = CLR_M1;
        end else if (start) begin
          st_d = ST_BLO; tmr_ld = 1'b1; tmr_val = LO_M1;
          sh_ld = 1'b1; bit_clr = 1'b1; dev_set = 1'b1;
        end
      end
      ST_BLO: if (tmr_zero) begin
        st_d = ST_BHI; tmr_ld = 1'b1; tmr_val = HI_M1;
      end
      ST_BHI: if (tmr_zero) begin
        sh_go = 1'b1; tmr_ld = 1'b1; tmr_val = LO_M1;
        if (bit_last) st_d = ST_GAP;
        else begin st_d = ST_BLO; bit_inc = 1'b1; end
      end
      ST_GAP: if (tmr_zero) begin
        tmr_ld = 1'b1; tmr_val = LO_M1;
        if (load_here) st_d = ST_LLO;
        else begin st_d = ST_BLO; dev_dec = 1'b1; bit_clr = 1'b1; end
      end
      ST_LLO: if (tmr_zero) begin
        st_d = ST_LHI; tmr_ld = 1'b1; tmr_val = HI_M1;
      end
      ST_LHI: if (tmr_zero) begin
        if (par_q && dev != '0) begin
          st_d = ST_BLO; tmr_ld = 1'b1; tmr_val = LO_M1;
          dev_dec = 1'b1; bit_clr = 1'b1;
        end else st_d = ST_FIN;
      end
      ST_CLR: if (tmr_zero) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      par_q   <= 1'b0;
      each_q  <= 1'b0;
      bit_cnt <= '0;
      dev     <= '0;
    end else begin
      st <= st_d;
      if (sh_ld) begin
        par_q  <= mode_par;
        each_q <= upd_each;
      end
      if (bit_clr)      bit_cnt <= '0;
      else if (bit_inc) bit_cnt <= bit_cnt + 1'b1;
      if (dev_set)      dev <= DW'(NDEV - 1);
      else if (dev_dec) dev <= dev - 1'b1;
    end
  end

  assign in_bits = (st == ST_BLO) || (st == ST_BHI);
  assign dclk    = (st == ST_BHI) || (st == ST_LHI);
  assign sdata   = in_bits && sh_msb;
  assign load_n  = !((st == ST_LLO) || (st == ST_LHI));
  assign clr_n   = (st != ST_CLR);
  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_FIN);

  for (genvar d = 0; d < NDEV; d++) begin : g_en
    assign shift_n[d] = !(in_bits && (!par_q || dev == DW'(d)));
  end

  // ---------------- checks on the produced waveforms ----------------
  logic        dclk_q, clr_q;
  logic [NDEV+1:0] sig, sig_q;
  logic [15:0] ph_len, sig_age, clr_len;

  assign sig = {sdata, load_n, shift_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      clr_q   <= 1'b1;
      sig_q   <= {1'b0, 1'b1, {NDEV{1'b1}}};
      ph_len  <= '0;
      sig_age <= '0;
      clr_len <= '0;
    end else begin
      dclk_q <= dclk;
      clr_q  <= clr_n;
      sig_q  <= sig;
      ph_len  <= (dclk != dclk_q) ? 16'd1 : ((ph_len == '1) ? ph_len : ph_len + 1'b1);
      sig_age <= (sig != sig_q)   ? 16'd1 : ((sig_age == '1) ? sig_age : sig_age + 1'b1);
      clr_len <= (clr_n != clr_q) ? 16'd1 : ((clr_len == '1) ? clr_len : clr_len + 1'b1);
    end
  end

  // R5
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_q && !dclk) |-> (32'(ph_len) >= HI_CNT));
  // R5
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_q && dclk) |-> (32'(ph_len) >= LO_CNT));
  // R6
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_q && dclk) |-> ((sig == sig_q) && (32'(sig_age) >= LO_CNT)));
  // R7
  clr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && clr_n) |-> (32'(clr_len) >= CLR_CNT));
  // R8
  no_dual_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> (&shift_n));
  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_q |-> ($countones(~shift_n) <= 1));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

// File: tb/tb_sdac_chain_ctrl.sv
module tb_sdac_chain_ctrl;

  localparam int NDEV   = 3;
  localparam int WORD_W = 16;
  localparam int CLK_NS = 4;
  localparam int TOT    = NDEV * WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_par = 1'b0, upd_each = 1'b0, start = 1'b0, clr_go = 1'b0;
  logic [TOT-1:0] codes = '0;
  logic busy, done, dclk, sdata, load_n, clr_n;
  logic [NDEV-1:0] shift_n;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sdac_chain_ctrl #(.NDEV(NDEV), .WORD_W(WORD_W), .CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .upd_each(upd_each),
    .start(start), .clr_go(clr_go), .codes(codes), .busy(busy), .done(done),
    .dclk(dclk), .sdata(sdata), .shift_n(shift_n), .load_n(load_n), .clr_n(clr_n)
  );

  // ---------- behavioural converter models ----------
  logic [TOT-1:0]  dac_all;
  logic [NDEV-1:0] sdo_all;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic [WORD_W-1:0] ir, dr;
    logic sdi;
    if (d == 0) begin : g_first
      assign sdi = sdata;
    end else begin : g_rest
      assign sdi = mode_par ? sdata : sdo_all[d-1];
    end
    always @(posedge dclk or negedge clr_n) begin
      if (!clr_n) begin
        ir <= '0;
        dr <= '0;
      end else begin
        if (!shift_n[d]) ir <= {ir[WORD_W-2:0], sdi};
        if (!load_n)     dr <= ir;
      end
    end
    assign sdo_all[d] = ir[WORD_W-1];
    assign dac_all[d*WORD_W +: WORD_W] = dr;
  end

  // ---------- expected timing counts, found by search ----------
  function automatic int need_cycles(input int ns);
    int c = 0;
    while (c * CLK_NS < ns) c++;
    return c;
  endfunction

  int lo_e, hi_e, clr_e;

  // ---------- waveform monitor (negedge sampling) ----------
  int rises, load_strobes, min_hi, min_lo, su_bad, both_bad, multi_bad, min_clr;
  int run_d, age_s, run_c;
  logic pd, pl, pc;
  logic [NDEV+1:0] psig;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dclk != pd) begin
        if (pd) begin if (run_d < min_hi) min_hi = run_d; end
        else    begin if (run_d < min_lo) min_lo = run_d; end
        run_d = 1;
      end else run_d++;
      if ({sdata, load_n, shift_n} != psig) age_s = 1; else age_s++;
      if (dclk && !pd) begin
        rises++;
        if (age_s < lo_e + 1) su_bad++;
      end
      if (!load_n && pl) load_strobes++;
      if (!load_n && !(&shift_n)) both_bad++;
      if ($countones(~shift_n) > 1 && mode_par) multi_bad++;
      if (clr_n != pc) begin
        if (!pc && run_c < min_clr) min_clr = run_c;
        run_c = 1;
      end else run_c++;
      pd = dclk; pl = load_n; pc = clr_n;
      psig = {sdata, load_n, shift_n};
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    wait (cyc > 190000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  task automatic wait_done();
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done, "R9 done reached", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after start", busy, 1);
  endtask

  task automatic run_txn(input logic par, input logic each, input logic [TOT-1:0] cv,
                         input bit poke_busy);
    int exp_r, exp_l;
    mode_par = par; upd_each = each; codes = cv;
    rises = 0; load_strobes = 0;
    @(negedge clk);
    pulse_start();
    if (poke_busy) begin
      repeat (100) @(negedge clk);
      codes = ~cv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    repeat (3) @(negedge clk);
    for (int d = 0; d < NDEV; d++)
      chk(dac_all[d*WORD_W +: WORD_W] == cv[d*WORD_W +: WORD_W],
          par ? "R3 device code (parallel)" : "R1 device code (cascade)",
          dac_all[d*WORD_W +: WORD_W], cv[d*WORD_W +: WORD_W]);
    exp_r = (par && each) ? NDEV * (WORD_W + 1) : TOT + 1;
    exp_l = (par && each) ? NDEV : 1;
    chk(rises == exp_r, par ? "R4 dclk rises" : "R2 dclk rises", rises, exp_r);
    chk(load_strobes == exp_l, par ? "R4 load strobes" : "R2 load strobes", load_strobes, exp_l);
    if (poke_busy) begin
      repeat (200) @(negedge clk);
      chk(!busy, "R9 start while busy ignored", busy, 0);
    end
  endtask

  initial begin
    logic [TOT-1:0] rv;
    int seed_init;
    seed_init = $urandom(20240);
    lo_e  = need_cycles(50);
    hi_e  = need_cycles(50);
    while ((lo_e + hi_e) * CLK_NS < 100) hi_e++;
    clr_e = need_cycles(200);
    min_hi = 1 << 30; min_lo = 1 << 30; min_clr = 1 << 30;
    su_bad = 0; both_bad = 0; multi_bad = 0;
    run_d = 0; age_s = 0; run_c = 0;
    pd = 1'b0; pl = 1'b1; pc = 1'b1;
    psig = {1'b0, 1'b1, {NDEV{1'b1}}};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk({busy, done, dclk, sdata} == 4'b0, "R10 reset outputs low", {busy, done, dclk, sdata}, 0);
    chk(&shift_n && load_n && clr_n, "R10 reset enables high", {shift_n, load_n, clr_n}, '1);

    // directed: extreme two's-complement codes, cascade
    run_txn(1'b0, 1'b0, {16'h8000, 16'h7FFF, 16'hFFFF}, 1'b0);
    // directed: parallel, update after each device
    run_txn(1'b1, 1'b1, {16'h0001, 16'hC000, 16'h4000}, 1'b0);
    // directed: parallel, single update
    run_txn(1'b1, 1'b0, {16'hA5A5, 16'h0000, 16'h5A5A}, 1'b0);
    // R9 start while busy, cascade
    run_txn(1'b0, 1'b0, {16'h1234, 16'h5678, 16'h9ABC}, 1'b1);

    // R7 clear
    rises = 0;
    clr_go = 1'b1;
    @(negedge clk);
    clr_go = 1'b0;
    chk(busy, "R7 busy during clear", busy, 1);
    wait_done();
    repeat (2) @(negedge clk);
    chk(dac_all == '0, "R7 devices cleared", dac_all, 0);
    chk(min_clr >= clr_e, "R7 clear width", min_clr, clr_e);

    // R7 clear has priority over simultaneous start
    run_txn(1'b0, 1'b0, {16'h1111, 16'h2222, 16'h3333}, 1'b0);
    rises = 0;
    codes = {16'hDEAD, 16'hBEEF, 16'hCAFE};
    clr_go = 1'b1; start = 1'b1;
    @(negedge clk);
    clr_go = 1'b0; start = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    chk(rises == 0, "R7 clear wins: no data clocked", rises, 0);
    chk(dac_all == '0, "R7 clear wins: devices zero", dac_all, 0);

    // random mix of modes and codes
    for (int i = 0; i < 9; i++) begin
      for (int d = 0; d < NDEV; d++) rv[d*WORD_W +: WORD_W] = WORD_W'($urandom);
      run_txn(1'($urandom % 2), 1'($urandom % 2), rv, 1'b0);
    end

    // whole-run waveform checks
    chk(min_hi >= hi_e, "R5 min dclk high", min_hi, hi_e);
    chk(min_lo >= lo_e, "R5 min dclk low", min_lo, lo_e);
    chk(su_bad == 0, "R6 setup before rise", su_bad, 0);
    chk(both_bad == 0, "R8 load and shift low together", both_bad, 0);
    chk(multi_bad == 0, "R3 single select in parallel", multi_bad, 0);
    finish_run();
  end

endmodule